// File: doc/BRIEF.md
# Free-Memory Watermark Monitor

This block watches the number of free packet-buffer blocks and compares it, every clock, against three thresholds that the host programs through one register. Each threshold drives its own response. When the count falls under the interrupt level, the block emits a one-cycle interrupt request. When it falls under the flow-control level, the block holds a pause-frame request. When it falls under the receive-headroom level, the block closes the receiver's enable.

The headroom response respects frame boundaries. If no frame is arriving, the receive-enable drops on the next clock. If a frame is arriving, the receiver keeps running until that frame's end indication, and it stays closed for every frame after it. The headroom condition has hysteresis. It releases only when the count rises strictly above the threshold. A threshold of zero switches off its response, and writing zero releases any condition that threshold was holding.

Top module: `fmw_monitor`

## Requirements
- R1: A write (`thr_wr` high) loads `thr_wdata` into the threshold register on that clock edge. The interrupt level is bits [CNT_W-1:0], the pause level is bits [2*CNT_W-1:CNT_W] and the headroom level is bits [3*CNT_W-1:2*CNT_W]. Reset clears all three to zero. The outputs reflect a newly written value from the second edge after the write.
- R2: `wm_irq` is high for exactly one cycle. That cycle follows the first edge at which `free_blocks` is strictly less than a non-zero interrupt level. The pulse does not repeat while the count stays low. It re-arms once the count is at or above the level.
- R3: `pause_req` is high from the edge at which `free_blocks` is strictly less than a non-zero pause level. It goes low at the edge at which the count is at or above the level.
- R4: When `free_blocks` is strictly less than a non-zero headroom level and `rx_frame_active` is low, `rx_enable` is low after the next edge.
- R5: When the headroom condition arises while `rx_frame_active` is high, `rx_enable` stays high until the edge that samples `rx_frame_end` high, and it is low after that edge. A frame that starts while the receiver is halted does not raise `rx_enable`.
- R6: A held headroom condition persists while `free_blocks` equals the headroom level. It releases at the edge at which the count is strictly greater, and `rx_enable` is high after that edge.
- R7: A zero threshold produces no interrupt, no pause request and no receive halt, even at a count of zero. Writing zero releases the held pause or headroom condition at the second edge after the write.
- R8: During and just after reset, `rx_enable` is high and `wm_irq` and `pause_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| free_blocks | input | CNT_W | Current number of free buffer blocks |
| thr_wr | input | 1 | Threshold register write strobe |
| thr_wdata | input | 3*CNT_W | Packed interrupt, pause and headroom levels |
| rx_frame_active | input | 1 | A frame is being received |
| rx_frame_end | input | 1 | Last cycle of the frame being received |
| wm_irq | output | 1 | One-cycle low-watermark interrupt request |
| pause_req | output | 1 | Request to transmit a pause frame |
| rx_enable | output | 1 | Receiver enable; low when halted |

## Verification
The bench builds the block with CNT_W = 6, so `free_blocks` spans 0 to 63. This narrow width lets it drive the count to zero and to full scale within a short run. It also lets it place a threshold at the top value, 63, so the strict-less-than compare is tested at the edge of the field. With the small width, one 18-bit write covers all three threshold fields. A level placed in one field that shows up on the wrong output exposes a swapped field layout.

// File: rtl/fmw_pkg.sv
package fmw_pkg;
  localparam int unsigned NUM_THR   = 3;
  localparam int unsigned IDX_INT   = 0;
  localparam int unsigned IDX_PAUSE = 1;
  localparam int unsigned IDX_HEAD  = 2;

  typedef enum logic [1:0] {
    RXG_OPEN   = 2'd0,
    RXG_DRAIN  = 2'd1,
    RXG_HALTED = 2'd2
  } rxg_state_e;
endpackage

// File: rtl/fmw_thr_reg.sv
module fmw_thr_reg #(
  parameter int unsigned CNT_W = 12,
  parameter int unsigned NUM   = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [NUM*CNT_W-1:0]       wdata,
  output logic [NUM-1:0][CNT_W-1:0]  thr
);
  logic [NUM-1:0][CNT_W-1:0] thr_q, thr_d;

  always_comb begin
    thr_d = thr_q;
    if (wr_en) begin
      for (int i = 0; i < int'(NUM); i++) begin
        thr_d[i] = wdata[i*CNT_W +: CNT_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) thr_q <= '0;
    else        thr_q <= thr_d;
  end

  assign thr = thr_q;

  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (thr_q == $past(wdata))); // R1
endmodule

// File: rtl/fmw_level_cmp.sv
module fmw_level_cmp #(
  parameter int unsigned CNT_W = 12,
  parameter bit          HYST  = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] level,
  input  logic [CNT_W-1:0] thr,
  output logic             hit_d,
  output logic             hit_q
);
  logic thr_on;
  assign thr_on = (thr != '0);

  always_comb begin
    if (!thr_on)           hit_d = 1'b0;
    else if (level < thr)  hit_d = 1'b1;
    else if (HYST)         hit_d = (level > thr) ? 1'b0 : hit_q;
    else                   hit_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_q <= 1'b0;
    else        hit_q <= hit_d;
  end

  AST_BELOW_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_on && (level < thr)) |=> hit_q); // R3
  AST_ZERO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (!thr_on) |=> !hit_q); // R7

  generate
    if (HYST) begin : g_hyst_chk
      AST_EQUAL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_q && thr_on && (level == thr)) |=> hit_q); // R6
    end
  endgenerate
endmodule

// File: rtl/fmw_rx_gate.sv
module fmw_rx_gate
  import fmw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic halt_d,
  input  logic frame_active,
  input  logic frame_end,
  output logic rx_en
);
  rxg_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      RXG_OPEN: begin
        if (halt_d) st_d = (frame_active && !frame_end) ? RXG_DRAIN : RXG_HALTED;
      end
      RXG_DRAIN: begin
        if (!halt_d)                         st_d = RXG_OPEN;
        else if (frame_end || !frame_active) st_d = RXG_HALTED;
      end
      RXG_HALTED: begin
        if (!halt_d) st_d = RXG_OPEN;
      end
      default: st_d = RXG_OPEN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= RXG_OPEN;
    else        st_q <= st_d;
  end

  assign rx_en = (st_q != RXG_HALTED);

  AST_IDLE_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_d && !frame_active) |=> !rx_en); // R4
  AST_FRAME_FINISHES: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_en && frame_active && !frame_end) |=> rx_en); // R5
  AST_NO_REOPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en && halt_d) |=> !rx_en); // R5
endmodule

// File: rtl/fmw_monitor.sv
module fmw_monitor
  import fmw_pkg::*;
#(
  parameter int unsigned CNT_W = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [CNT_W-1:0]         free_blocks,
  input  logic                     thr_wr,
  input  logic [NUM_THR*CNT_W-1:0] thr_wdata,
  input  logic                     rx_frame_active,
  input  logic                     rx_frame_end,
  output logic                     wm_irq,
  output logic                     pause_req,
  output logic                     rx_enable
);
  logic [NUM_THR-1:0][CNT_W-1:0] thr;
  logic [NUM_THR-1:0]            hit_d, hit_q;
  logic                          irq_d, irq_q;

  fmw_thr_reg #(.CNT_W(CNT_W), .NUM(NUM_THR)) u_thr (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (thr_wr),
    .wdata (thr_wdata),
    .thr   (thr)
  );

  generate
    for (genvar i = 0; i < int'(NUM_THR); i++) begin : g_cmp
      localparam bit USE_HYST = (i == int'(IDX_HEAD));
      fmw_level_cmp #(.CNT_W(CNT_W), .HYST(USE_HYST)) u_cmp (
        .clk   (clk),
        .rst_n (rst_n),
        .level (free_blocks),
        .thr   (thr[i]),
        .hit_d (hit_d[i]),
        .hit_q (hit_q[i])
      );
    end
  endgenerate

  assign irq_d = hit_d[IDX_INT] & ~hit_q[IDX_INT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  fmw_rx_gate u_gate (
    .clk          (clk),
    .rst_n        (rst_n),
    .halt_d       (hit_d[IDX_HEAD]),
    .frame_active (rx_frame_active),
    .frame_end    (rx_frame_end),
    .rx_en        (rx_enable)
  );

  assign wm_irq    = irq_q;
  assign pause_req = hit_q[IDX_PAUSE];

  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wm_irq |=> !wm_irq); // R2
  AST_IRQ_NEEDS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (thr[IDX_INT] == '0) |=> !wm_irq); // R7
endmodule

// File: tb/sim_fmw_monitor.sv
module sim_fmw_monitor;
  localparam int unsigned W = 6;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [W-1:0]   free_blocks;
  logic           thr_wr;
  logic [3*W-1:0] thr_wdata;
  logic           rx_frame_active, rx_frame_end;
  logic           wm_irq, pause_req, rx_enable;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  fmw_monitor #(.CNT_W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .free_blocks(free_blocks), .thr_wr(thr_wr),
    .thr_wdata(thr_wdata), .rx_frame_active(rx_frame_active),
    .rx_frame_end(rx_frame_end), .wm_irq(wm_irq), .pause_req(pause_req),
    .rx_enable(rx_enable)
  );

  task automatic step(input int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic chk(input string req, input logic act, input logic exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic write_thr(input int ti, input int tp, input int th);
    thr_wdata = {th[W-1:0], tp[W-1:0], ti[W-1:0]};
    thr_wr    = 1'b1;
    step();
    thr_wr    = 1'b0;
    step();
  endtask

  task automatic t_reset;
    chk("R8", rx_enable, 1'b1, "rx_enable after reset");
    chk("R8", pause_req, 1'b0, "pause_req after reset");
    chk("R8", wm_irq,    1'b0, "wm_irq after reset");
    free_blocks = '0;
    step(3);
    chk("R7", wm_irq,    1'b0, "no irq at zero thresholds");
    chk("R7", pause_req, 1'b0, "no pause at zero thresholds");
    chk("R7", rx_enable, 1'b1, "no halt at zero thresholds");
  endtask

  task automatic t_irq;
    free_blocks = 6'd20;
    write_thr(10, 0, 0);
    chk("R2", wm_irq, 1'b0, "no irq above level");
    free_blocks = 6'd9;
    step();
    chk("R2", wm_irq, 1'b1, "irq on falling below");
    step();
    chk("R2", wm_irq, 1'b0, "irq single cycle");
    free_blocks = 6'd5;
    step();
    chk("R2", wm_irq, 1'b0, "no repeat while low");
    chk("R1", pause_req, 1'b0, "interrupt field not seen as pause");
    free_blocks = 6'd10;
    step();
    chk("R2", wm_irq, 1'b0, "no irq at equal");
    free_blocks = 6'd9;
    step();
    chk("R2", wm_irq, 1'b1, "irq re-armed");
    free_blocks = 6'd12;
    step();
    thr_wdata = {6'd0, 6'd0, 6'd13};
    thr_wr    = 1'b1;
    step();
    thr_wr    = 1'b0;
    chk("R1", wm_irq, 1'b0, "new level not yet in effect");
    step();
    chk("R1", wm_irq, 1'b1, "new level effective second edge");
  endtask

  task automatic t_pause;
    free_blocks = 6'd20;
    write_thr(0, 8, 0);
    chk("R3", pause_req, 1'b0, "pause low above level");
    free_blocks = 6'd7;
    step();
    chk("R3", pause_req, 1'b1, "pause high below level");
    chk("R1", rx_enable, 1'b1, "pause field not seen as headroom");
    step(2);
    chk("R3", pause_req, 1'b1, "pause level held");
    free_blocks = 6'd8;
    step();
    chk("R3", pause_req, 1'b0, "pause drops at equal");
    free_blocks = 6'd62;
    write_thr(0, 63, 0);
    chk("R3", pause_req, 1'b1, "pause at full-scale level");
    free_blocks = 6'd63;
    step();
    chk("R3", pause_req, 1'b0, "pause clears at full scale");
    free_blocks = 6'd3;
    step();
    chk("R3", pause_req, 1'b1, "pause before zero write");
    write_thr(0, 0, 0);
    chk("R7", pause_req, 1'b0, "zero write releases pause");
  endtask

  task automatic t_head;
    rx_frame_active = 1'b0;
    rx_frame_end    = 1'b0;
    free_blocks     = 6'd30;
    write_thr(0, 0, 16);
    chk("R4", rx_enable, 1'b1, "open above headroom");
    free_blocks = 6'd15;
    step();
    chk("R4", rx_enable, 1'b0, "idle halt next clock");
    chk("R1", wm_irq,    1'b0, "headroom field not seen as interrupt");
    free_blocks = 6'd16;
    step(2);
    chk("R6", rx_enable, 1'b0, "equal keeps halt");
    free_blocks = 6'd17;
    step();
    chk("R6", rx_enable, 1'b1, "release above level");
    rx_frame_active = 1'b1;
    step();
    free_blocks = 6'd10;
    step();
    chk("R5", rx_enable, 1'b1, "frame keeps running");
    step(2);
    chk("R5", rx_enable, 1'b1, "still running mid-frame");
    rx_frame_end = 1'b1;
    step();
    rx_frame_end    = 1'b0;
    rx_frame_active = 1'b0;
    chk("R5", rx_enable, 1'b0, "halt at frame end");
    step();
    rx_frame_active = 1'b1;
    step(2);
    chk("R5", rx_enable, 1'b0, "new frame stays blocked");
    rx_frame_active = 1'b0;
    write_thr(0, 0, 0);
    chk("R7", rx_enable, 1'b1, "zero write releases halt");
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0;
    free_blocks = '0;
    thr_wr = 1'b0;
    thr_wdata = '0;
    rx_frame_active = 1'b0;
    rx_frame_end = 1'b0;
    step(3);
    chk("R8", rx_enable, 1'b1, "rx_enable during reset");
    rst_n = 1'b1;
    step();
    t_reset();
    t_irq();
    t_pause();
    t_head();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule